// File: doc/BRIEF.md
# Line Sensor Host Controller

This block is the host-side master for a 102-pixel linear light sensor that has a three-wire serial link. It makes the serial clock from the system clock and drives the command line. It also samples the sensor's data line. One `start` pulse runs the bring-up ritual the first time. That ritual is a long idle-high preamble, then three reset commands, then the writing of the three zone offsets, the three zone gains and the zeroed mode register. After bring-up the block runs an acquisition: start integration, wait a programmable number of serial clocks, issue a combined sample-and-read command, then deframe the 102 pixel bytes that come back.

Each received pixel leaves as a one-cycle strobe carrying the byte and its position in the line. A completion strobe marks the end of a full line. With `loop_en` high, the block uses the read command that also restarts integration, so it goes on capturing lines without a separate start command. The link runs UART-style framing in both directions: one low start bit, eight data bits LSB first, one high stop bit. Every command is followed by a fixed idle-high gap.

Top module: `lsa_host_ctrl`

## Requirements
- R1: While reset is held, `sclk` and `sdin` are high, `busy` is low and no pixel strobe is given.
- R2: After the first `start` following reset, `sdin` stays high for at least 30 rising edges of `sclk` before the first command start bit.
- R3: The first three command bytes after the preamble are the reset opcode 0x1B.
- R4: Register writes follow the resets as 14 bytes, each a command byte 0x40|address followed by a data byte. The three offsets go first, to addresses 0, 2 and 4 (zones 0, 1, 2). The three gains follow, to addresses 1, 3 and 5, zero-extended from 5 bits. Zero is written last, to address 0x1F.
- R5: Every transmitted byte is framed as a start bit 0, eight data bits LSB first and a stop bit 1. `sdin` changes only at `sclk` falling edges. At least 8 idle-high `sclk` cycles separate a stop bit from the next start bit.
- R6: Without loop mode, an acquisition sends 0x08 and then the read opcode 0x12. At least `int_clocks` idle `sclk` cycles lie between the two.
- R7: `sdout` is sampled at `sclk` rising edges. Each correctly framed byte yields a one-cycle `pix_valid` with `pix_data` equal to the byte and `pix_index` counting from 0 to 101 in arrival order. `frame_done` pulses in the cycle after the strobe for index 101.
- R8: With `loop_en` high, the read opcode is 0x16. After each completed line the block waits `int_clocks` and sends 0x16 again, with no 0x08 in between.
- R9: A low level where a stop bit is due gives a one-cycle `frame_err`, produces no strobe for that byte, ends the capture without `frame_done`, and returns the block to idle.
- R10: `sdout` is ignored outside a capture window. Activity on it during the preamble, the commands or idle produces no `pix_valid`.
- R11: The high and low phases of `sclk` each last `SCLK_HALF` system clocks. The default gives phases of at least 30 ns and a rate of at most 10 MHz from a 100 MHz clock.
- R12: A `start` after bring-up has completed skips the preamble, the resets and the register writes. It begins directly with 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin bring-up (first time) and acquisition |
| loop_en | input | 1 | Continuous capture using the read-and-restart opcode |
| int_clocks | input | INT_W | Integration time in serial clocks |
| cfg_offset | input | 3x8 | Signed dark-level offset per zone |
| cfg_gain | input | 3x5 | Gain code per zone |
| sdout | input | 1 | Serial data from the sensor |
| sclk | output | 1 | Serial clock to the sensor |
| sdin | output | 1 | Serial command data to the sensor |
| busy | output | 1 | High whenever the sequencer is not idle |
| pix_valid | output | 1 | One-cycle strobe for a received pixel |
| pix_data | output | 8 | Pixel value |
| pix_index | output | 7 | Pixel position in the line |
| frame_done | output | 1 | Pulse after the last pixel of a line |
| frame_err | output | 1 | Pulse on a missing stop bit |

## Verification
The command side is judged in serial-clock units. The bench decodes `sdin` at each `sclk` rise and logs each byte's start-bit and stop-bit edge numbers. Preamble length, command gaps and integration spacing then come out as differences of edge counts, so system-clock latency does not affect them. A pixel strobe is due one system cycle after the `sclk` rise that samples the stop bit, and `frame_done` one cycle after that. The monitor samples every strobe at the falling edge of `clk` and compares it against the value the bench sensor model sent for that position. The counts for lines, errors and stray strobes are checked only once `busy` has dropped and the sensor model has gone quiet.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;
    localparam int NPIX     = 102;
    localparam int IDX_W    = $clog2(NPIX);
    localparam int NUM_REGS = 7;

    localparam logic [7:0] OP_RESET   = 8'h1B;
    localparam logic [7:0] OP_START   = 8'h08;
    localparam logic [7:0] OP_READ    = 8'h12;
    localparam logic [7:0] OP_READ_GO = 8'h16;
    localparam logic [7:0] OP_WRITE   = 8'h40;
    localparam logic [4:0] MODE_ADDR  = 5'h1F;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_RST, S_REG, S_START, S_INTEG, S_READ, S_CAPT
    } seq_state_t;

    typedef enum logic [1:0] { RX_HUNT, RX_DATA, RX_STOP } rx_state_t;

    typedef struct packed {
        logic [7:0]       data;
        logic [IDX_W-1:0] index;
    } pix_t;

    // Even steps carry the write command, odd steps the data.
    // Offsets (addresses 0,2,4) first, gains (1,3,5) next, mode last.
    function automatic logic [7:0] reg_seq_byte(
        input logic [3:0]      step,
        input logic [2:0][7:0] offs,
        input logic [2:0][4:0] gains
    );
        logic [2:0] n;
        logic [2:0] m;
        logic [4:0] addr;
        logic [7:0] data;
        n = step[3:1];
        m = n - 3'd3;
        if (n < 3'd3) begin
            addr = {2'b00, n[1:0], 1'b0};
            data = offs[n[1:0]];
        end else if (n < 3'd6) begin
            addr = {2'b00, m[1:0], 1'b1};
            data = {3'b000, gains[m[1:0]]};
        end else begin
            addr = MODE_ADDR;
            data = 8'h00;
        end
        return step[0] ? data : (OP_WRITE | {3'b000, addr});
    endfunction
endpackage

// File: rtl/lsa_clk_div.sv
`timescale 1ns/1ps
module lsa_clk_div #(
    parameter int SCLK_HALF = 5
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic fall_tick,
    output logic rise_tick
);
    localparam int DW = $clog2(SCLK_HALF + 1);

    logic [DW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == DW'(SCLK_HALF - 1));
    assign fall_tick = wrap & sclk;
    assign rise_tick = wrap & ~sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lsa_tx_frame.sv
`timescale 1ns/1ps
module lsa_tx_frame #(
    parameter int GAP_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fall_tick,
    input  logic       go,
    input  logic [7:0] tx_data,
    output logic       sdin,
    output logic       busy,
    output logic       done
);
    localparam int FW = GAP_CLKS + 10;
    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            cnt  <= '0;
            busy <= 1'b0;
            sdin <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                sh   <= {{GAP_CLKS{1'b1}}, 1'b1, tx_data, 1'b0};
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy && fall_tick) begin
                sdin <= sh[0];
                sh   <= {1'b1, sh[FW-1:1]};
                if (cnt == CW'(FW - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: the command line moves only on a serial-clock falling edge
    p_sdin_fall_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdin) |-> $past(fall_tick));
    // R5: a finished frame leaves the line idle high
    p_gap_high_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> sdin);
endmodule

// File: rtl/lsa_rx_deframe.sv
`timescale 1ns/1ps
module lsa_rx_deframe
    import lsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rise_tick,
    input  logic sdout,
    output logic pix_valid,
    output pix_t pix,
    output logic frame_done,
    output logic frame_err
);
    rx_state_t        st;
    logic [2:0]       bitc;
    logic [7:0]       sh;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st         <= RX_HUNT;
            bitc       <= '0;
            sh         <= '0;
            idx        <= '0;
            pix        <= '0;
            pix_valid  <= 1'b0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            pix_valid  <= 1'b0;
            frame_err  <= 1'b0;
            frame_done <= pix_valid && (pix.index == IDX_W'(NPIX - 1));
            if (rise_tick) begin
                case (st)
                    RX_HUNT: if (!sdout && idx < IDX_W'(NPIX)) begin
                        st   <= RX_DATA;
                        bitc <= '0;
                    end
                    RX_DATA: begin
                        sh <= {sdout, sh[7:1]};
                        if (bitc == 3'd7) st <= RX_STOP;
                        bitc <= bitc + 1'b1;
                    end
                    default: begin
                        st <= RX_HUNT;
                        if (sdout) begin
                            pix_valid <= 1'b1;
                            pix.data  <= sh;
                            pix.index <= idx;
                            idx       <= idx + 1'b1;
                        end else begin
                            frame_err <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R7: indices stay inside the line
    p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix.index < IDX_W'(NPIX)));
    // R7: completion follows the strobe of the last pixel
    p_done_last_r7: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> ($past(pix_valid) && $past(pix.index) == IDX_W'(NPIX - 1)));
    // R9: an error never coincides with a pixel strobe
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(pix_valid && frame_err));
endmodule

// File: rtl/lsa_host_ctrl.sv
`timescale 1ns/1ps
module lsa_host_ctrl
    import lsa_pkg::*;
#(
    parameter int SCLK_HALF = 5,
    parameter int GAP_CLKS  = 8,
    parameter int PRE_CLKS  = 30,
    parameter int NUM_RST   = 3,
    parameter int INT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   loop_en,
    input  logic [INT_W-1:0]       int_clocks,
    input  logic [2:0][7:0]        cfg_offset,
    input  logic [2:0][4:0]        cfg_gain,
    input  logic                   sdout,
    output logic                   sclk,
    output logic                   sdin,
    output logic                   busy,
    output logic                   pix_valid,
    output logic [7:0]             pix_data,
    output logic [IDX_W-1:0]       pix_index,
    output logic                   frame_done,
    output logic                   frame_err
);
    localparam int REG_STEPS = 2 * NUM_REGS;

    seq_state_t       state;
    logic [INT_W-1:0] cnt;
    logic [3:0]       step;
    logic             sent, inited;
    logic             fall_tick, rise_tick;
    logic             tx_go, tx_busy, tx_done, is_cmd, cap_en;
    logic [7:0]       tx_byte;
    pix_t             pix;

    lsa_clk_div #(.SCLK_HALF(SCLK_HALF)) i_div (
        .clk(clk), .rst(rst), .sclk(sclk),
        .fall_tick(fall_tick), .rise_tick(rise_tick));

    lsa_tx_frame #(.GAP_CLKS(GAP_CLKS)) i_tx (
        .clk(clk), .rst(rst), .fall_tick(fall_tick), .go(tx_go),
        .tx_data(tx_byte), .sdin(sdin), .busy(tx_busy), .done(tx_done));

    lsa_rx_deframe i_rx (
        .clk(clk), .rst(rst), .en(cap_en), .rise_tick(rise_tick),
        .sdout(sdout), .pix_valid(pix_valid), .pix(pix),
        .frame_done(frame_done), .frame_err(frame_err));

    assign pix_data  = pix.data;
    assign pix_index = pix.index;
    assign busy      = (state != S_IDLE);
    assign cap_en    = (state == S_CAPT);
    assign is_cmd    = (state == S_RST) || (state == S_REG) ||
                       (state == S_START) || (state == S_READ);
    assign tx_go     = is_cmd && !sent && !tx_busy;

    always_comb begin
        case (state)
            S_RST:   tx_byte = OP_RESET;
            S_REG:   tx_byte = reg_seq_byte(step, cfg_offset, cfg_gain);
            S_START: tx_byte = OP_START;
            S_READ:  tx_byte = loop_en ? OP_READ_GO : OP_READ;
            default: tx_byte = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cnt    <= '0;
            step   <= '0;
            sent   <= 1'b0;
            inited <= 1'b0;
        end else begin
            if (tx_go) sent <= 1'b1;
            if (tx_done) sent <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    state <= inited ? S_START : S_PRE;
                    cnt   <= '0;
                    step  <= '0;
                end
                S_PRE: if (fall_tick) begin
                    if (cnt == INT_W'(PRE_CLKS - 1)) state <= S_RST;
                    else cnt <= cnt + 1'b1;
                end
                S_RST: if (tx_done) begin
                    if (step == 4'(NUM_RST - 1)) begin
                        state <= S_REG;
                        step  <= '0;
                    end else step <= step + 1'b1;
                end
                S_REG: if (tx_done) begin
                    if (step == 4'(REG_STEPS - 1)) begin
                        state  <= S_START;
                        inited <= 1'b1;
                    end else step <= step + 1'b1;
                end
                S_START: if (tx_done) begin
                    state <= S_INTEG;
                    cnt   <= '0;
                end
                S_INTEG: if (fall_tick) begin
                    if (cnt >= int_clocks) state <= S_READ;
                    else cnt <= cnt + 1'b1;
                end
                S_READ: if (tx_done) state <= S_CAPT;
                default: begin
                    if (frame_err) state <= S_IDLE;
                    else if (frame_done) begin
                        state <= loop_en ? S_INTEG : S_IDLE;
                        cnt   <= '0;
                    end
                end
            endcase
        end
    end

    // R9: a framing error closes the capture window
    p_err_ends_r9: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> (state != S_CAPT));
    // R10: no strobe once the capture window is shut
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (state != S_CAPT) |=> !pix_valid);
    // R12: the preamble runs only before bring-up has finished
    p_init_once_r12: assert property (@(posedge clk) disable iff (rst)
        (state == S_PRE) |-> !inited);
endmodule

// File: tb/test_lsa_host_ctrl.sv
`timescale 1ns/1ps
module test_lsa_host_ctrl;
    import lsa_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int INT_CLK    = 50;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, loop_en = 1'b0;
    logic [15:0] int_clocks = 16'(INT_CLK);
    logic [2:0][7:0] cfg_offset;
    logic [2:0][4:0] cfg_gain;
    logic sdout = 1'b1;
    logic sclk, sdin, busy, pix_valid, frame_done, frame_err;
    logic [7:0] pix_data;
    logic [IDX_W-1:0] pix_index;

    int checks = 0, errors = 0;
    int rise_cnt = 0, nbytes = 0, stop_bad = 0;
    logic [7:0] log_b [64];
    int se [64];
    int pe [64];
    bit noise_en = 0, resp_pend = 0, resp_active = 0;
    int fr = 0, bad_idx = 255;
    int got = 0, fgot = 0, bad = 0, stray = 0, dones = 0, errs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsa_host_ctrl i_lsa_host_ctrl (
        .clk(clk), .rst(rst), .start(start), .loop_en(loop_en),
        .int_clocks(int_clocks), .cfg_offset(cfg_offset), .cfg_gain(cfg_gain),
        .sdout(sdout), .sclk(sclk), .sdin(sdin), .busy(busy),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_index(pix_index),
        .frame_done(frame_done), .frame_err(frame_err));

    function automatic logic [7:0] pix_val(int k, int f);
        return 8'(k * 3 + f * 29 + 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick_rise();
        @(posedge sclk);
        rise_cnt++;
    endtask

    // sensor model: command decoder on the serial clock rises
    initial begin
        logic [7:0] b;
        int st;
        forever begin
            tick_rise();
            if (sdin === 1'b0) begin
                st = rise_cnt;
                for (int i = 0; i < 8; i++) begin
                    tick_rise();
                    b[i] = sdin;
                end
                tick_rise();
                if (sdin !== 1'b1) stop_bad++;
                if (nbytes < 64) begin
                    log_b[nbytes] = b;
                    se[nbytes] = st;
                    pe[nbytes] = rise_cnt;
                end
                nbytes++;
                if (b == OP_READ || b == OP_READ_GO) begin
                    noise_en = 0;
                    resp_pend = 1;
                end
            end
        end
    end

    // sensor model: pixel responder and idle noise on the falling edges
    initial begin
        logic [7:0] v;
        forever begin
            @(negedge sclk);
            if (resp_pend) begin
                resp_pend = 0;
                resp_active = 1;
                fr++;
                sdout <= 1'b1;
                repeat (19) @(negedge sclk);
                for (int k = 0; k < NPIX; k++) begin
                    v = pix_val(k, fr);
                    @(negedge sclk) sdout <= 1'b0;
                    for (int j = 0; j < 8; j++) @(negedge sclk) sdout <= v[j];
                    @(negedge sclk) sdout <= (k == bad_idx) ? 1'b0 : 1'b1;
                end
                @(negedge sclk) sdout <= 1'b1;
                resp_active = 0;
            end else begin
                sdout <= noise_en ? rise_cnt[1] : 1'b1;
            end
        end
    end

    // pixel monitor
    initial forever begin
        @(negedge clk);
        if (pix_valid) begin
            if (!resp_active) stray++;
            if (pix_index !== IDX_W'(fgot) || pix_data !== pix_val(fgot, fr)) bad++;
            got++;
            fgot++;
        end
        if (frame_done) begin dones++; fgot = 0; end
        if (frame_err) begin errs++; fgot = 0; end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic clear_counts();
        nbytes = 0; stop_bad = 0; got = 0; fgot = 0; bad = 0;
        stray = 0; dones = 0; errs = 0;
    endtask

    task automatic run_and_wait(bit loop_stop_after3);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (loop_stop_after3) begin
            while (nbytes < 3) @(negedge clk);
            loop_en = 1'b0;
        end
        while (busy || resp_active) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(sclk === 1'b1, "R1 sclk in reset", sclk, 1);
        check(sdin === 1'b1, "R1 sdin in reset", sdin, 1);
        check(busy === 1'b0 && pix_valid === 1'b0, "R1 busy/pix_valid in reset",
              {busy, pix_valid}, 0);
    endtask

    task automatic t_clock();
        realtime t0, t1, t2;
        @(posedge sclk) t0 = $realtime;
        @(negedge sclk) t1 = $realtime;
        @(posedge sclk) t2 = $realtime;
        check((t1 - t0) >= 30.0, "R11 sclk high phase ns", int'(t1 - t0), 30);
        check((t2 - t1) >= 30.0, "R11 sclk low phase ns", int'(t2 - t1), 30);
        check((t2 - t0) >= 100.0, "R11 sclk period ns", int'(t2 - t0), 100);
    endtask

    task automatic t_single();
        logic [7:0] exp_reg [14] = '{8'h40, 8'h10, 8'h42, 8'h85, 8'h44, 8'h7F,
                                     8'h41, 8'h03, 8'h43, 8'h1F, 8'h45, 8'h00,
                                     8'h5F, 8'h00};
        int rise_at_start, mism, rst_ok, min_gap;
        clear_counts();
        loop_en = 1'b0;
        bad_idx = 255;
        noise_en = 1;
        rise_at_start = rise_cnt;
        run_and_wait(1'b0);
        check(nbytes == 19, "R6 byte count of bring-up and one line", nbytes, 19);
        check(se[0] - rise_at_start - 1 >= 30, "R2 preamble high clocks",
              se[0] - rise_at_start - 1, 30);
        rst_ok = 0;
        for (int i = 0; i < 3; i++) if (log_b[i] == 8'h1B) rst_ok++;
        check(rst_ok == 3, "R3 reset opcodes", rst_ok, 3);
        mism = 0;
        for (int i = 0; i < 14; i++) if (log_b[3 + i] !== exp_reg[i]) mism++;
        check(mism == 0, "R4 register write bytes mismatching", mism, 0);
        check(log_b[15] == 8'h5F && log_b[16] == 8'h00, "R4 mode write",
              log_b[16], 0);
        min_gap = 1000;
        for (int i = 1; i < 19; i++)
            if (se[i] - pe[i - 1] - 1 < min_gap) min_gap = se[i] - pe[i - 1] - 1;
        check(min_gap >= 8, "R5 minimum idle gap", min_gap, 8);
        check(stop_bad == 0, "R5 stop bits", stop_bad, 0);
        check(log_b[17] == 8'h08, "R6 start integration opcode", log_b[17], 8);
        check(log_b[18] == 8'h12, "R6 read opcode", log_b[18], 18);
        check(se[18] - pe[17] - 1 >= INT_CLK, "R6 integration spacing",
              se[18] - pe[17] - 1, INT_CLK);
        check(got == NPIX, "R7 pixel count", got, NPIX);
        check(bad == 0, "R7 pixel value/index mismatches", bad, 0);
        check(dones == 1, "R7 frame_done count", dones, 1);
        check(stray == 0, "R10 strobes outside capture", stray, 0);
    endtask

    task automatic t_loop();
        clear_counts();
        loop_en = 1'b1;
        noise_en = 1;
        run_and_wait(1'b1);
        check(nbytes == 3, "R8 byte count of looped run", nbytes, 3);
        check(log_b[0] == 8'h08, "R12 restart begins with start opcode", log_b[0], 8);
        check(log_b[1] == 8'h16 && log_b[2] == 8'h16, "R8 read-and-restart opcodes",
              log_b[2], 22);
        check(se[2] - pe[1] - 1 >= INT_CLK, "R8 integration before second read",
              se[2] - pe[1] - 1, INT_CLK);
        check(dones == 2 && got == 2 * NPIX, "R8 two lines captured", got, 2 * NPIX);
        check(bad == 0, "R7 looped pixel mismatches", bad, 0);
        check(stray == 0, "R10 strobes outside capture in loop", stray, 0);
    endtask

    task automatic t_error();
        clear_counts();
        loop_en = 1'b0;
        bad_idx = 40;
        noise_en = 1;
        run_and_wait(1'b0);
        check(log_b[0] == 8'h08 && log_b[1] == 8'h12, "R12 restart opcodes",
              log_b[0], 8);
        check(errs == 1, "R9 frame_err pulses", errs, 1);
        check(got == 40, "R9 pixels before bad stop", got, 40);
        check(dones == 0, "R9 no frame_done", dones, 0);
        check(bad == 0, "R9 pixel mismatches before error", bad, 0);
        check(busy == 1'b0, "R9 back to idle", busy, 0);
        bad_idx = 255;
    endtask

    initial begin
        cfg_offset[0] = 8'h10; cfg_offset[1] = 8'h85; cfg_offset[2] = 8'h7F;
        cfg_gain[0] = 5'd3; cfg_gain[1] = 5'd31; cfg_gain[2] = 5'd0;
        t_reset();
        @(negedge clk) rst = 1'b0;
        t_clock();
        t_single();
        t_loop();
        t_error();
        report();
    end
endmodule